// File: doc/BRIEF.md
# External character generator address logic

This block sits between a video display generator and an external font memory. It builds the font memory address from three fields. The top bits come from a bank select that is set from outside the block. The middle bits are a character code taken from the display data. The low bits are a row counter, so all the rows of one character sit at consecutive addresses. Each character takes a 16-byte cell: bitmap rows fill the first 12 bytes and the last 4 are padding. A 15-bit address covers 16 complete font sets in 32 KB.

The row counter advances on every change of the low display-address bit. A clear or a reload uses two active-low inputs, frame sync and row preset:

- While frame sync is low, an arming latch is cleared and the counter is held at zero.
- The latch is set by the first falling edge of row preset after frame sync returns high. Until then, the counter stays at zero whatever the address bit does.
- Once the latch is set, the counter is cleared only while row preset is low.

This keeps the first text row of a frame aligned to row 0.

The block also steers the data inputs of the generator. Bit 7 always passes straight through from the display data. That bit is the alpha/semigraphics flag, and it selects the source of bits 6:0, which come either from the font memory or from the display data. Everything runs on one clock. The address bit and row preset are edge-detected against their values in the previous cycle.

Top module: `chargen_addr`

## Requirements
- R1: `font_addr_o` is `{bank_i[3:0], disp_data_i[6:0], row[3:0]}`, with bank in bits 14:11, character code in bits 10:4 and the row counter in bits 3:0. The address follows `bank_i` and `disp_data_i` in the same cycle.
- R2: While `frame_sync_ni` is low at a clock edge, the row counter becomes 0 after that edge and the arming latch is cleared.
- R3: While the arming latch is cleared, the row counter stays at 0 regardless of `da0_i` activity. The first text row after frame start therefore begins at row 0.
- R4: With `frame_sync_ni` high, a high-to-low change of `row_preset_ni` sets the arming latch at the next edge. The latch stays set until `frame_sync_ni` goes low again.
- R5: While the latch is set and `row_preset_ni` is low, the row counter is held at 0.
- R6: While the latch is set and both `frame_sync_ni` and `row_preset_ni` are high, each change of `da0_i` advances the row counter by one after the next clock edge. A rising change and a falling change count the same.
- R7: The row counter wraps from 15 to 0 when no clear condition applies.
- R8: `vdg_data_o[7]` always equals `disp_data_i[7]`.
- R9: When `disp_data_i[7]` is 0, `vdg_data_o[6:0]` equals `font_data_i[6:0]`. When it is 1, `vdg_data_o[6:0]` equals `disp_data_i[6:0]`.
- R10: After `rst_ni` is asserted, the row counter is 0 and the latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_sync_ni | input | 1 | Active-low frame sync from the generator |
| row_preset_ni | input | 1 | Active-low row preset from the generator |
| da0_i | input | 1 | Low display-address bit; each change steps the row |
| bank_i | input | 4 | Font bank select |
| disp_data_i | input | 8 | Display data; bit 7 is the alpha/semigraphics flag |
| font_data_i | input | 7 | Bitmap byte read from font memory (bit 7 not used) |
| font_addr_o | output | 15 | Font memory address |
| vdg_data_o | output | 8 | Data presented to the video generator |

## Verification
Several properties are checked on every cycle:
- the hold while frame sync is low, while the latch is cleared and while row preset is low;
- the single-step advance and wrap on each address-bit change;
- the latch staying set;
- the address field layout and both steering paths.

Only the bench's scenarios can show the full sequence. In that sequence, toggles during frame sync are ignored, the first row after the arming preset starts at 0, and a mid-row preset restarts the count. After a second frame sync, toggles are again ignored until a new preset arrives. Sweeps over all banks and codes, and over every display byte, confirm the address and data values against a computed font model.

// File: rtl/chargen_pkg.sv
package chargen_pkg;
  localparam int ROW_W  = 4;
  localparam int CODE_W = 7;
  localparam int BANK_W = 4;
  localparam int ADDR_W = BANK_W + CODE_W + ROW_W;
  localparam int DATA_W = CODE_W + 1;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_kind_e;
endpackage

// File: rtl/chargen_edge.sv
module chargen_edge
  import chargen_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_ANY,
  parameter bit         IDLE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= sig_i;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign hit_o = sig_i & ~prev_q;
    end else if (KIND == EDGE_FALL) begin : g_fall
      assign hit_o = ~sig_i & prev_q;
    end else begin : g_any
      assign hit_o = sig_i ^ prev_q;
    end
  endgenerate
endmodule

// File: rtl/chargen_row_ctr.sv
module chargen_row_ctr #(
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_sync_ni,
  input  logic             row_preset_ni,
  input  logic             preset_fall_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic             armed_o
);
  logic             armed_q;
  logic [ROW_W-1:0] row_q;
  logic             clear;

  // latch: cleared for the whole frame-sync pulse, armed by first preset after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             armed_q <= 1'b0;
    else if (!frame_sync_ni) armed_q <= 1'b0;
    else if (preset_fall_i)  armed_q <= 1'b1;
  end

  // clear = latch cleared, or latch set with preset active
  assign clear = ~armed_q | ~row_preset_ni | ~frame_sync_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (clear)  row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end

  assign row_o   = row_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/chargen_steer.sv
module chargen_steer #(
  parameter int CODE_W = 7
) (
  input  logic [CODE_W:0]   disp_i,
  input  logic [CODE_W-1:0] font_i,
  output logic [CODE_W:0]   out_o
);
  logic use_disp;
  assign use_disp = disp_i[CODE_W];

  // flag bit always passes straight through
  assign out_o[CODE_W] = disp_i[CODE_W];

  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign out_o[b] = use_disp ? disp_i[b] : font_i[b];
  end
endmodule

// File: rtl/chargen_addr.sv
module chargen_addr
  import chargen_pkg::*;
#(
  parameter int P_ROW_W  = ROW_W,
  parameter int P_CODE_W = CODE_W,
  parameter int P_BANK_W = BANK_W,
  localparam int P_ADDR_W = P_BANK_W + P_CODE_W + P_ROW_W,
  localparam int P_DATA_W = P_CODE_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_sync_ni,
  input  logic                row_preset_ni,
  input  logic                da0_i,
  input  logic [P_BANK_W-1:0] bank_i,
  input  logic [P_DATA_W-1:0] disp_data_i,
  input  logic [P_CODE_W-1:0] font_data_i,
  output logic [P_ADDR_W-1:0] font_addr_o,
  output logic [P_DATA_W-1:0] vdg_data_o
);
  logic               preset_fall;
  logic               da_step;
  logic               armed;
  logic [P_ROW_W-1:0] row;

  chargen_edge #(.KIND(EDGE_FALL), .IDLE(1'b1)) u_preset_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (row_preset_ni),
    .hit_o (preset_fall)
  );

  chargen_edge #(.KIND(EDGE_ANY), .IDLE(1'b0)) u_da_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (da0_i),
    .hit_o (da_step)
  );

  chargen_row_ctr #(.ROW_W(P_ROW_W)) u_row (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_sync_ni(frame_sync_ni),
    .row_preset_ni(row_preset_ni),
    .preset_fall_i(preset_fall),
    .step_i       (da_step),
    .row_o        (row),
    .armed_o      (armed)
  );

  assign font_addr_o = {bank_i, disp_data_i[P_CODE_W-1:0], row};

  chargen_steer #(.CODE_W(P_CODE_W)) u_steer (
    .disp_i(disp_data_i),
    .font_i(font_data_i),
    .out_o (vdg_data_o)
  );
endmodule

// File: rtl/chargen_addr_chk.sv
module chargen_addr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        frame_sync_ni,
  input logic        row_preset_ni,
  input logic        da0_i,
  input logic [3:0]  bank_i,
  input logic [7:0]  disp_data_i,
  input logic [6:0]  font_data_i,
  input logic [14:0] font_addr_o,
  input logic [7:0]  vdg_data_o,
  input logic        armed
);
  logic       da_seen_q;
  logic       seen_valid_q;
  logic [3:0] row;

  assign row = font_addr_o[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_seen_q    <= 1'b0;
      seen_valid_q <= 1'b0;
    end else begin
      da_seen_q    <= da0_i;
      seen_valid_q <= 1'b1;
    end
  end

  a_r1_addr_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    font_addr_o[14:4] == {bank_i, disp_data_i[6:0]});

  a_r2_fs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_sync_ni |=> (row == 4'd0) && !armed);

  a_r3_unarmed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> row == 4'd0);

  a_r4_latch_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && frame_sync_ni |=> armed);

  a_r5_preset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_preset_ni |=> row == 4'd0);

  // R6 and R7: step by one, modulo 16
  a_r6_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_valid_q && armed && frame_sync_ni && row_preset_ni && (da0_i != da_seen_q)
    |=> row == $past(row) + 4'd1);

  a_r6_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_valid_q && (da0_i == da_seen_q) |=> row == 4'd0 || $stable(row));

  a_r8_flag_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vdg_data_o[7] == disp_data_i[7]);

  a_r9_external: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_data_i[7] |-> vdg_data_o[6:0] == font_data_i);

  a_r9_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_data_i[7] |-> vdg_data_o[6:0] == disp_data_i[6:0]);
endmodule

bind chargen_addr chargen_addr_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_sync_ni(frame_sync_ni),
  .row_preset_ni(row_preset_ni),
  .da0_i        (da0_i),
  .bank_i       (bank_i),
  .disp_data_i  (disp_data_i),
  .font_data_i  (font_data_i),
  .font_addr_o  (font_addr_o),
  .vdg_data_o   (vdg_data_o),
  .armed        (armed)
);

// File: tb/chargen_addr_test.sv
`timescale 1ns/1ps
module chargen_addr_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_sync_ni = 1'b1;
  logic        row_preset_ni = 1'b1;
  logic        da0_i = 1'b0;
  logic [3:0]  bank_i = 4'd0;
  logic [7:0]  disp_data_i = 8'd0;
  logic [6:0]  font_data_i;
  logic [14:0] font_addr_o;
  logic [7:0]  vdg_data_o;

  int total = 0;
  int bad = 0;
  int exp_row = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [6:0] font_fn(input logic [14:0] a);
    font_fn = a[6:0] ^ a[13:7] ^ {6'd0, a[14]} ^ 7'h55;
  endfunction

  assign font_data_i = font_fn(font_addr_o);

  chargen_addr uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_sync_ni(frame_sync_ni),
    .row_preset_ni(row_preset_ni),
    .da0_i        (da0_i),
    .bank_i       (bank_i),
    .disp_data_i  (disp_data_i),
    .font_data_i  (font_data_i),
    .font_addr_o  (font_addr_o),
    .vdg_data_o   (vdg_data_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic toggle_check(input string req);
    da0_i = ~da0_i;
    tick();
    check(req, int'(font_addr_o[3:0]), exp_row);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    finish_up();
  end

  initial begin
    tick();
    tick();
    // R10 reset state
    check("R10", int'(font_addr_o[3:0]), 0);
    rst_ni = 1'b1;
    tick();

    // R3: frame sync high, latch never armed: toggles ignored
    exp_row = 0;
    for (int i = 0; i < 6; i++) toggle_check("R3");

    // R2: toggles during frame sync are ignored
    frame_sync_ni = 1'b0;
    tick();
    for (int i = 0; i < 4; i++) toggle_check("R2");
    frame_sync_ni = 1'b1;
    tick();
    toggle_check("R3");

    // R4/R5: arming preset, counter held while preset low
    row_preset_ni = 1'b0;
    tick();
    check("R5", int'(font_addr_o[3:0]), 0);
    for (int i = 0; i < 3; i++) toggle_check("R5");
    row_preset_ni = 1'b1;
    tick();
    // first text row after frame start begins at row 0
    check("R3", int'(font_addr_o[3:0]), 0);

    // R6/R7: count through a wrap
    for (int i = 1; i <= 20; i++) begin
      exp_row = i % 16;
      toggle_check(i == 16 ? "R7" : "R6");
    end
    // no change of da0 -> no step
    tick();
    check("R6", int'(font_addr_o[3:0]), exp_row);

    // R5: mid-row preset restarts count; R4 latch stays armed
    row_preset_ni = 1'b0;
    tick();
    check("R5", int'(font_addr_o[3:0]), 0);
    row_preset_ni = 1'b1;
    tick();
    for (int i = 1; i <= 3; i++) begin
      exp_row = i;
      toggle_check("R4");
    end

    // R2: new frame sync clears the latch; toggles ignored until next preset
    frame_sync_ni = 1'b0;
    tick();
    check("R2", int'(font_addr_o[3:0]), 0);
    frame_sync_ni = 1'b1;
    tick();
    exp_row = 0;
    for (int i = 0; i < 3; i++) toggle_check("R2");
    row_preset_ni = 1'b0;
    tick();
    row_preset_ni = 1'b1;
    tick();
    for (int i = 1; i <= 5; i++) begin
      exp_row = i;
      toggle_check("R4");
    end

    // R1: sweep every bank and code at the current row
    for (int b = 0; b < 16; b++) begin
      for (int c = 0; c < 128; c++) begin
        bank_i = 4'(b);
        disp_data_i = {1'b0, 7'(c)};
        #0.5;
        check("R1", int'(font_addr_o), (b << 11) | (c << 4) | exp_row);
      end
    end

    // R8/R9: sweep every display byte over several banks
    for (int b = 0; b < 16; b += 5) begin
      for (int d = 0; d < 256; d++) begin
        logic [14:0] a;
        logic [6:0]  f;
        bank_i = 4'(b);
        disp_data_i = 8'(d);
        #0.5;
        a = 15'((b << 11) | ((d & 127) << 4) | exp_row);
        f = font_fn(a);
        check("R8", int'(vdg_data_o[7]), (d >> 7) & 1);
        check("R9", int'(vdg_data_o[6:0]), (d >= 128) ? (d & 127) : int'(f));
      end
    end

    tick();
    finish_up();
  end
endmodule